// File: doc/BRIEF.md
# Power Transition Sequencer Engine

This block is the sequencing core of a power-management companion. A small script memory holds instructions that are linked to each other by next-pointers. Each instruction carries a 16-bit power-bus message and a delay. Software reaches the block through a byte-wide write port. Through that port it opens the configuration guard with a two-value key, loads the script memory one byte at a time through an address register and a data register, and sets a start index for each kind of transition.

Four trigger inputs request a transition: going to sleep, waking processor groups 1 and 2, waking group 3, and warm reset. When one of them fires, the engine follows the linked list from that transition's start index. For every instruction it puts the message on a parallel output with a one-cycle valid strobe. It then counts the instruction's delay in ticks of a slow timebase before it moves on. It stops after the instruction whose link is the end marker.

The per-group event settings control two things. They gate the warm-reset trigger, and they make the wake triggers respond to the input level instead of a rising edge. The serial bus that carries the messages is outside this block, and so is the regulator control.

Top module: `pwr_seq_engine`

## Requirements
- R1: After reset the outputs `msg_valid`, `msg_data` and `busy` are 0. Configuration is locked. All start indices and event settings are 0. Every script-memory byte holds 0xFF.
- R2: While configuration is locked, writes to the memory-address register (address 1), the memory-data register (address 2), the start-index registers (addresses 3 to 6) and the event registers (addresses 7 to 9) have no effect.
- R3: Configuration unlocks only when 0xC0 and then 0x0C are written, in that order, to the key register (address 0). In the middle of that sequence, a key write with any other value returns the guard to locked.
- R4: While configuration is unlocked, any write to the key register (0x00 is the usual value) locks configuration again.
- R5: Instruction k occupies bytes 4k to 4k+3. These bytes hold, in order, the message high byte, the message low byte, the delay and the next index. A data write stores its byte at the byte address held in the address register. A message is either singular or broadcast:
  - A singular message has bit 12 = 0. It carries the device group in bits [15:13], an 8-bit resource ID in [11:4] and the state in [3:0].
  - A broadcast message has bit 12 = 1. It carries the device group in [15:13], the resource group in [11:9], resource type-2 in [8:7], the resource type in [6:4] and the state in [3:0].
  - The state codes are 0xF for warm reset, 0xE for active, 0x8 for sleep and 0x0 for off.
  - The device groups are 0x1, 0x2 and 0x4, and 0x0 means none.
  - The block emits {high byte, low byte} unchanged.
- R6: A next-index byte of 0x3F or above ends the script after that instruction. Any smaller value is the index of the next instruction.
- R7: After an instruction's strobe, the engine waits for the number of `tick` pulses given by the delay byte. A tick counts if it is seen in the strobe cycle or later. With a delay of 0, the next instruction's strobe follows on the very next cycle.
- R8: The start-index registers are ordered as follows: address 3 for sleep, 4 for the group 1/2 wake, 5 for the group 3 wake and 6 for warm reset. The first strobe of a run appears on the third rising edge, counting the edge that first samples the trigger as the first.
- R9: A trigger that arrives during a run is held pending and served after the run ends. Among pending triggers the order is warm reset, then sleep, then group 1/2 wake, then group 3 wake.
- R10: A warm-reset trigger is accepted only while bit 4 is set in at least one of the three event registers (addresses 7, 8 and 9). Otherwise it is dropped.
- R11: Bit 3 of an event register selects level sensitivity:
  - Bit 3 of register 7 or 8 applies to the group 1/2 wake trigger.
  - Bit 3 of register 9 applies to the group 3 wake trigger.
  - In level mode, the trigger is requested on every cycle the input is high.
  - In edge mode, a request needs a rising edge.
  - The sleep and warm triggers always act on a rising edge.
- R12: `busy` is high from the cycle after a run starts, through the last strobe of the run, and in every strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tick | input | 1 | Slow timebase pulse for delays |
| trig_sleep | input | 1 | Request the active-to-sleep transition |
| trig_wake12 | input | 1 | Request the sleep-to-active transition for groups 1/2 |
| trig_wake3 | input | 1 | Request the sleep-to-active transition for group 3 |
| trig_warm | input | 1 | Request the warm-reset transition |
| msg_valid | output | 1 | One-cycle strobe for each emitted message |
| msg_data | output | 16 | Emitted power-bus message |
| busy | output | 1 | A sequence is in progress |

## Verification
The output timing is fixed:
- A register write takes effect at the edge that samples it, so it governs the following cycle.
- A trigger's first strobe is visible after the third rising edge, counting from the edge that samples the trigger.
- A zero-delay link puts the next strobe one cycle later.
- A nonzero delay releases the next instruction one cycle after its last tick, and that instruction's strobe follows one cycle after the release.

The bench keeps a behavioural model that advances on each rising edge with these latencies. It compares `msg_valid`, `busy` and, on strobes, `msg_data` at every falling edge, away from the edge where they change. For each scenario it also compares the captured message list against values built from the message encoding.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_RUN  = 2'd1,
        EX_WAIT = 2'd2
    } exec_e;

    localparam int NUM_TRIG    = 4;
    localparam int TRIG_SLEEP  = 0;
    localparam int TRIG_WAKE12 = 1;
    localparam int TRIG_WAKE3  = 2;
    localparam int TRIG_WARM   = 3;

    localparam int NUM_GRP = 3;

    localparam logic [3:0] RA_KEY    = 4'd0;
    localparam logic [3:0] RA_MADDR  = 4'd1;
    localparam logic [3:0] RA_MDATA  = 4'd2;
    localparam logic [3:0] RA_PTR_SL = 4'd3;
    localparam logic [3:0] RA_PTR_W12 = 4'd4;
    localparam logic [3:0] RA_PTR_W3 = 4'd5;
    localparam logic [3:0] RA_PTR_WR = 4'd6;
    localparam logic [3:0] RA_EVT_G1 = 4'd7;
    localparam logic [3:0] RA_EVT_G2 = 4'd8;
    localparam logic [3:0] RA_EVT_G3 = 4'd9;

    localparam logic [7:0] KEY_FIRST  = 8'hC0;
    localparam logic [7:0] KEY_SECOND = 8'h0C;

    localparam int EVT_WARM_BIT = 4;
    localparam int EVT_LVL_BIT  = 3;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pseq_cfg.sv
module pseq_cfg
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [3:0]                         addr,
    input  logic [BYTE_W-1:0]                  wdata,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [2*BYTE_W-1:0]                rd_msg,
    output logic [BYTE_W-1:0]                  rd_dly,
    output logic [BYTE_W-1:0]                  rd_nxt,
    output logic [NUM_TRIG-1:0][IDX_W-1:0]     start_ptr,
    output logic                               warm_en,
    output logic                               lvl_wake12,
    output logic                               lvl_wake3,
    output logic                               open
);
    localparam int BA_W   = IDX_W + 2;
    localparam int NBYTES = 1 << BA_W;

    typedef struct packed {
        lock_e                           lock;
        logic [BA_W-1:0]                 maddr;
        logic [NUM_TRIG-1:0][IDX_W-1:0]  ptr;
        logic [NUM_GRP-1:0]              warm;
        logic [NUM_GRP-1:0]              lvl;
    } cfg_s;

    cfg_s q, d;
    logic mem_we;
    logic [BYTE_W-1:0] mem [NBYTES];

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (wr) begin
            unique case (addr)
                RA_KEY: begin
                    unique case (q.lock)
                        LK_LOCKED: d.lock = (wdata == KEY_FIRST)  ? LK_HALF : LK_LOCKED;
                        LK_HALF:   d.lock = (wdata == KEY_SECOND) ? LK_OPEN : LK_LOCKED;
                        default:   d.lock = LK_LOCKED;
                    endcase
                end
                RA_MADDR:   if (q.lock == LK_OPEN) d.maddr = wdata[BA_W-1:0];
                RA_MDATA:   mem_we = (q.lock == LK_OPEN);
                RA_PTR_SL:  if (q.lock == LK_OPEN) d.ptr[TRIG_SLEEP]  = wdata[IDX_W-1:0];
                RA_PTR_W12: if (q.lock == LK_OPEN) d.ptr[TRIG_WAKE12] = wdata[IDX_W-1:0];
                RA_PTR_W3:  if (q.lock == LK_OPEN) d.ptr[TRIG_WAKE3]  = wdata[IDX_W-1:0];
                RA_PTR_WR:  if (q.lock == LK_OPEN) d.ptr[TRIG_WARM]   = wdata[IDX_W-1:0];
                RA_EVT_G1, RA_EVT_G2, RA_EVT_G3: begin
                    if (q.lock == LK_OPEN) begin
                        d.warm[addr - RA_EVT_G1] = wdata[EVT_WARM_BIT];
                        d.lvl[addr - RA_EVT_G1]  = wdata[EVT_LVL_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{lock: LK_LOCKED, maddr: '0, ptr: '0, warm: '0, lvl: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= '1;
        end else if (mem_we) begin
            mem[q.maddr] <= wdata;
        end
    end

    logic [BYTE_W-1:0] rd_bytes [4];
    for (genvar b = 0; b < 4; b++) begin : g_rd
        assign rd_bytes[b] = mem[{rd_idx, 2'(b)}];
    end

    assign rd_msg     = {rd_bytes[0], rd_bytes[1]};
    assign rd_dly     = rd_bytes[2];
    assign rd_nxt     = rd_bytes[3];
    assign start_ptr  = q.ptr;
    assign warm_en    = |q.warm;
    assign lvl_wake12 = q.lvl[0] | q.lvl[1];
    assign lvl_wake3  = q.lvl[2];
    assign open       = (q.lock == LK_OPEN);

endmodule

// File: rtl/pseq_arb.sv
module pseq_arb
    import pwr_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TRIG-1:0]  trig_in,
    input  logic                 warm_en,
    input  logic                 lvl_wake12,
    input  logic                 lvl_wake3,
    input  logic                 idle,
    output logic                 start,
    output logic [1:0]           sel
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] prev;
        logic [NUM_TRIG-1:0] pend;
    } arb_s;

    arb_s q, d;
    logic [NUM_TRIG-1:0] rise, ev, clr;
    logic [NUM_TRIG-1:0] level_mode;

    assign level_mode = {1'b0, lvl_wake3, lvl_wake12, 1'b0};

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_ev
        assign rise[t] = trig_in[t] & ~q.prev[t];
        if (t == TRIG_WARM) begin : g_warm
            assign ev[t] = rise[t] & warm_en;
        end else begin : g_other
            assign ev[t] = level_mode[t] ? trig_in[t] : rise[t];
        end
    end

    always_comb begin
        d     = q;
        start = idle & (|q.pend);
        sel   = 2'(TRIG_WAKE3);
        if (q.pend[TRIG_WARM])        sel = 2'(TRIG_WARM);
        else if (q.pend[TRIG_SLEEP])  sel = 2'(TRIG_SLEEP);
        else if (q.pend[TRIG_WAKE12]) sel = 2'(TRIG_WAKE12);
        clr = start ? (NUM_TRIG'(1) << sel) : '0;
        d.pend = (q.pend & ~clr) | ev;
        d.prev = trig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pseq_exec.sv
module pseq_exec
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     start_idx,
    input  logic                 tick,
    input  logic [2*BYTE_W-1:0]  rd_msg,
    input  logic [BYTE_W-1:0]    rd_dly,
    input  logic [BYTE_W-1:0]    rd_nxt,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 msg_valid,
    output logic [2*BYTE_W-1:0]  msg_data,
    output logic                 busy,
    output logic                 idle
);
    localparam logic [BYTE_W-1:0] END_IDX = BYTE_W'((1 << IDX_W) - 1);

    typedef struct packed {
        exec_e                st;
        logic [IDX_W-1:0]     pc;
        logic [BYTE_W-1:0]    cnt;
        logic [BYTE_W-1:0]    nxt;
        logic                 valid;
        logic [2*BYTE_W-1:0]  msg;
        logic                 busy;
    } exec_s;

    exec_s q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            EX_IDLE: begin
                if (start) begin
                    d.st = EX_RUN;
                    d.pc = start_idx;
                end
            end
            EX_RUN: begin
                d.valid = 1'b1;
                d.msg   = rd_msg;
                if (rd_dly == '0) begin
                    if (rd_nxt >= END_IDX) d.st = EX_IDLE;
                    else                   d.pc = rd_nxt[IDX_W-1:0];
                end else begin
                    d.st  = EX_WAIT;
                    d.cnt = rd_dly;
                    d.nxt = rd_nxt;
                end
            end
            EX_WAIT: begin
                if (tick) begin
                    if (q.cnt == BYTE_W'(1)) begin
                        if (q.nxt >= END_IDX) begin
                            d.st = EX_IDLE;
                        end else begin
                            d.st = EX_RUN;
                            d.pc = q.nxt[IDX_W-1:0];
                        end
                    end else begin
                        d.cnt = q.cnt - BYTE_W'(1);
                    end
                end
            end
            default: d.st = EX_IDLE;
        endcase
        d.busy = (d.st != EX_IDLE) | d.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: EX_IDLE, pc: '0, cnt: '0, nxt: '0, valid: 1'b0, msg: '0, busy: 1'b0};
        else        q <= d;
    end

    assign rd_idx    = q.pc;
    assign msg_valid = q.valid;
    assign msg_data  = q.msg;
    assign busy      = q.busy;
    assign idle      = (q.st == EX_IDLE);

endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        tick,
    input  logic        trig_sleep,
    input  logic        trig_wake12,
    input  logic        trig_wake3,
    input  logic        trig_warm,
    output logic        msg_valid,
    output logic [15:0] msg_data,
    output logic        busy
);
    logic [IDX_W-1:0]               rd_idx;
    logic [2*BYTE_W-1:0]            rd_msg;
    logic [BYTE_W-1:0]              rd_dly, rd_nxt;
    logic [NUM_TRIG-1:0][IDX_W-1:0] start_ptr;
    logic                           warm_en, lvl_wake12, lvl_wake3, cfg_open;
    logic                           arb_start, exec_idle;
    logic [1:0]                     arb_sel;
    logic [NUM_TRIG-1:0]            trig_vec;

    assign trig_vec = {trig_warm, trig_wake3, trig_wake12, trig_sleep};

    pseq_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_msg(rd_msg), .rd_dly(rd_dly), .rd_nxt(rd_nxt),
        .start_ptr(start_ptr), .warm_en(warm_en), .lvl_wake12(lvl_wake12),
        .lvl_wake3(lvl_wake3), .open(cfg_open)
    );

    pseq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_vec), .warm_en(warm_en),
        .lvl_wake12(lvl_wake12), .lvl_wake3(lvl_wake3), .idle(exec_idle),
        .start(arb_start), .sel(arb_sel)
    );

    pseq_exec #(.IDX_W(IDX_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .start(arb_start), .start_idx(start_ptr[arb_sel]),
        .tick(tick), .rd_msg(rd_msg), .rd_dly(rd_dly), .rd_nxt(rd_nxt),
        .rd_idx(rd_idx), .msg_valid(msg_valid), .msg_data(msg_data),
        .busy(busy), .idle(exec_idle)
    );

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr,
    input logic [3:0]                cfg_addr,
    input logic                      cfg_open,
    input logic [NUM_TRIG*IDX_W-1:0] ptrs,
    input logic                      arb_start,
    input logic                      busy,
    input logic                      msg_valid
);
    assert_strobe_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> busy);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_start |=> busy);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !arb_start) |=> !msg_valid);

    assert_locked_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_open) |=> $stable(ptrs));

    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == RA_KEY && cfg_open) |=> !cfg_open);

endmodule

bind pwr_seq_engine pwr_seq_checker #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_open(cfg_open), .ptrs(start_ptr), .arb_start(arb_start),
    .busy(busy), .msg_valid(msg_valid)
);

// File: tb/tb_pwr_seq_engine.sv
module tb_pwr_seq_engine;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, cfg_wr = 1'b0, tick = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic trig_sleep = 0, trig_wake12 = 0, trig_wake3 = 0, trig_warm = 0;
    logic msg_valid, busy;
    logic [15:0] msg_data;

    pwr_seq_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tick(tick), .trig_sleep(trig_sleep),
        .trig_wake12(trig_wake12), .trig_wake3(trig_wake3), .trig_warm(trig_warm),
        .msg_valid(msg_valid), .msg_data(msg_data), .busy(busy)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    string req_tag = "R1";
    bit tick_en = 1'b1;
    int got_q[$];
    int stamp_q[$];

    task automatic chk(string tag, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // reference model
    int m_mem[256];
    int m_lock, m_maddr, m_st, m_pc, m_cnt, m_nxt;
    int m_ptr[4], m_warm[3], m_lvl[3], m_prev[4], m_pend[4], m_in[4], m_ev[4];
    bit e_valid, e_busy;
    int e_msg;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            m_lock = 0; m_maddr = 0; m_st = 0; m_pc = 0; m_cnt = 0; m_nxt = 0;
            foreach (m_ptr[i]) begin m_ptr[i] = 0; m_prev[i] = 0; m_pend[i] = 0; end
            foreach (m_warm[i]) begin m_warm[i] = 0; m_lvl[i] = 0; end
            e_valid = 0; e_busy = 0; e_msg = 0;
        end else begin
            int sel, base, dl, nx;
            bit go;
            m_in[0] = trig_sleep; m_in[1] = trig_wake12; m_in[2] = trig_wake3; m_in[3] = trig_warm;
            for (int t = 0; t < 4; t++) m_ev[t] = m_in[t] && !m_prev[t];
            if (m_lvl[0] || m_lvl[1]) m_ev[1] = m_in[1];
            if (m_lvl[2]) m_ev[2] = m_in[2];
            if (!(m_warm[0] || m_warm[1] || m_warm[2])) m_ev[3] = 0;
            go = (m_st == 0) && (m_pend[0] || m_pend[1] || m_pend[2] || m_pend[3]);
            sel = m_pend[3] ? 3 : m_pend[0] ? 0 : m_pend[1] ? 1 : 2;
            e_valid = 0;
            if (m_st == 0) begin
                if (go) begin m_st = 1; m_pc = m_ptr[sel]; end
            end else if (m_st == 1) begin
                base = m_pc * 4;
                e_valid = 1;
                e_msg = m_mem[base] * 256 + m_mem[base + 1];
                dl = m_mem[base + 2]; nx = m_mem[base + 3];
                if (dl == 0) begin
                    if (nx >= 63) m_st = 0; else m_pc = nx;
                end else begin
                    m_st = 2; m_cnt = dl; m_nxt = nx;
                end
            end else if (tick) begin
                if (m_cnt == 1) begin
                    if (m_nxt >= 63) m_st = 0; else begin m_st = 1; m_pc = m_nxt; end
                end else m_cnt--;
            end
            if (go) m_pend[sel] = 0;
            for (int t = 0; t < 4; t++) begin
                if (m_ev[t]) m_pend[t] = 1;
                m_prev[t] = m_in[t];
            end
            if (cfg_wr) begin
                if (cfg_addr == 0) begin
                    if (m_lock == 0) m_lock = (cfg_wdata == 8'hC0) ? 1 : 0;
                    else if (m_lock == 1) m_lock = (cfg_wdata == 8'h0C) ? 2 : 0;
                    else m_lock = 0;
                end else if (m_lock == 2) begin
                    case (cfg_addr)
                        1: m_maddr = cfg_wdata;
                        2: m_mem[m_maddr] = cfg_wdata;
                        3, 4, 5, 6: m_ptr[cfg_addr - 3] = cfg_wdata % 64;
                        7, 8, 9: begin
                            m_warm[cfg_addr - 7] = cfg_wdata[4];
                            m_lvl[cfg_addr - 7] = cfg_wdata[3];
                        end
                        default: ;
                    endcase
                end
            end
            e_busy = (m_st != 0) || e_valid;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_tag, "msg_valid", msg_valid, e_valid);
            chk("R12", "busy", busy, e_busy);
            if (e_valid) chk(req_tag, "msg_data", msg_data, e_msg);
            if (msg_valid) begin got_q.push_back(msg_data); stamp_q.push_back(cyc); end
        end
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick = tick_en && (ph == 0);
            ph = (ph + 1) % 3;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    function automatic int mk_single(int dg, int id, int st);
        return (dg << 13) | (id << 4) | st;
    endfunction
    function automatic int mk_bcast(int dg, int rg, int rt2, int rt, int st);
        return (dg << 13) | (1 << 12) | (rg << 9) | (rt2 << 7) | (rt << 4) | st;
    endfunction

    task automatic wr(int a, int v);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 4'(a); cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic put_ins(int idx, int msg, int dly, int nxt);
        int b[4];
        b[0] = msg >> 8; b[1] = msg & 255; b[2] = dly; b[3] = nxt;
        for (int i = 0; i < 4; i++) begin
            wr(1, idx * 4 + i);
            wr(2, b[i]);
        end
    endtask

    task automatic set_trig(int mask);
        trig_sleep = mask[0]; trig_wake12 = mask[1]; trig_wake3 = mask[2]; trig_warm = mask[3];
    endtask

    task automatic pulse(int mask);
        @(negedge clk); set_trig(mask);
        @(negedge clk); set_trig(0);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int i = 0; i < 3000 && quiet < 6; i++) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic cmp_run(string tag, int exp[$]);
        chk(tag, "message count", got_q.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got_q.size(); i++)
            chk(tag, "message", got_q[i], exp[i]);
        got_q.delete(); stamp_q.delete();
    endtask

    int S1, B1, K1, K2, W3, WA1, WA2;

    initial begin
        S1  = mk_single(1, 'h0F, 'h0);
        B1  = mk_bcast(0, 7, 0, 7, 'h8);
        K1  = mk_single(1, 'h10, 'hE);
        K2  = mk_bcast(0, 5, 0, 7, 'hE);
        W3  = mk_single(4, 'h19, 'hE);
        WA1 = mk_single(0, 'h1B, 'h0);
        WA2 = mk_single(1, 'h07, 'hF);

        repeat (3) @(negedge clk);
        chk("R1", "reset msg_valid", msg_valid, 0);
        chk("R1", "reset msg_data", msg_data, 0);
        chk("R1", "reset busy", busy, 0);
        rst_n = 1;

        // R2: locked writes ignored; start index 0 with erased memory
        req_tag = "R2";
        wr(3, 2);
        put_ins(0, 'h1234, 0, 63);
        pulse(1);
        wait_idle();
        cmp_run("R2", '{'hFFFF});

        // unlock and program (R5, R6, R8)
        req_tag = "R5";
        wr(0, 'hC0); wr(0, 'h0C);
        put_ins(2, S1, 3, 5);
        put_ins(5, B1, 0, 63);
        put_ins(10, K1, 0, 11);
        put_ins(11, K2, 2, 63);
        put_ins(20, W3, 1, 70);
        put_ins(30, WA1, 0, 31);
        put_ins(31, WA2, 0, 63);
        wr(3, 2); wr(4, 10); wr(5, 20); wr(6, 30);
        pulse(1);
        wait_idle();
        cmp_run("R5", '{S1, B1});

        req_tag = "R7";
        pulse(2);
        wait_idle();
        chk("R7", "zero-delay strobe spacing", (stamp_q.size() == 2) ? stamp_q[1] - stamp_q[0] : -1, 1);
        cmp_run("R8", '{K1, K2});

        req_tag = "R6";
        pulse(4);
        wait_idle();
        cmp_run("R6", '{W3});

        // R4: relock, then ignored writes
        req_tag = "R4";
        wr(0, 'h00);
        put_ins(20, 'hBEEF, 0, 63);
        wr(5, 2);
        pulse(4);
        wait_idle();
        cmp_run("R4", '{W3});

        // R3: broken key sequences stay locked
        req_tag = "R3";
        wr(0, 'hC0); wr(0, 'h55); wr(0, 'h0C);
        wr(5, 10);
        pulse(4);
        wait_idle();
        cmp_run("R3", '{W3});
        wr(0, 'h0C); wr(0, 'hC0);
        wr(5, 10);
        pulse(4);
        wait_idle();
        cmp_run("R3", '{W3});
        wr(0, 'h00);
        wr(0, 'hC0); wr(0, 'h0C);

        // R10: warm gated by event bit 4
        req_tag = "R10";
        pulse(8);
        wait_idle();
        cmp_run("R10", '{});
        wr(8, 'h10);
        pulse(8);
        wait_idle();
        cmp_run("R10", '{WA1, WA2});

        // R9: pending triggers and warm priority
        req_tag = "R9";
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(12);
        wait_idle();
        cmp_run("R9", '{S1, B1, WA1, WA2, W3});

        // R11: edge versus level wake
        req_tag = "R11";
        @(negedge clk); set_trig(4);
        repeat (60) @(negedge clk);
        set_trig(0);
        wait_idle();
        cmp_run("R11", '{W3});
        wr(9, 'h08);
        @(negedge clk); set_trig(4);
        repeat (60) @(negedge clk);
        set_trig(0);
        wait_idle();
        chk("R11", "level mode repeats", got_q.size() >= 2, 1);
        got_q.delete(); stamp_q.delete();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule